// File: doc/BRIEF.md
# Host-Selectable Sample Rate Generator

This block produces the sample-enable pulses that pace a two-converter acquisition channel. All timing lives in one synchronous domain whose clock period is the 10 ns sample slot. The 50 MHz base reference is therefore one phase every two cycles, and the fastest setting gives one pulse per cycle. The two converters take turns, which yields an aggregate 100 MSPS from two 50 MSPS conversion streams in antiphase.

The host drives a 3-bit rate code and an 8-bit reload value N. The two fastest reduced rates come from fixed power-of-two division. The slow range comes from a 6.25 MHz prescaled step, which a programmable counter divides by N+1. A synchronized external clock can be chosen instead of the internal rates.

Each rate pulse is steered to exactly one of two conversion enables, alternately. Both enables leave the same register stage, so their delays match. A global enable holds every output inactive. A new code or reload value is taken up only where a pulse is emitted, so a period is never cut short.

Top module: `sample_rate_gen`

## Requirements
- R1: While reset is asserted and until the internal reset release completes, `rate_o`, `conv_a_o` and `conv_b_o` are 0.
- R2: With rate code 0 and the enable high, `rate_o` is 1 in every cycle.
- R3: Rate code 1 gives one `rate_o` pulse every 2 cycles, and rate code 2 gives one pulse every 4 cycles.
- R4: Rate code 3 gives one `rate_o` pulse every 16*(N+1) cycles, where N is `div_i` in the range 0 to 255. N = 127 gives 2048 cycles, which is 48.8 kSPS.
- R5: Rate code 4 gives exactly one single-cycle `rate_o` pulse per rising edge of `ext_clk_i`. The pulse is high in the third cycle after the edge is first sampled. A level held high yields no further pulses.
- R6: Rate codes 5, 6 and 7 produce no pulse on any output.
- R7: While `en_i` is 0, all outputs are 0 from the next cycle on, and the period count restarts. For an internal code of period L, the first pulse is high L cycles after `en_i` is first sampled high.
- R8: In every cycle, exactly one of `conv_a_o` and `conv_b_o` is 1 when `rate_o` is 1, and neither is 1 otherwise. Pulses alternate between the two outputs, and the first pulse after the enable rises goes to `conv_a_o`.
- R9: A change of `sel_i` or `div_i` during a period is applied only at the next emitted pulse. The current period completes with the old setting, and the following period uses the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample-slot clock (10 ns period) |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Global output enable |
| sel_i | input | 3 | Rate code: 0 full, 1 half, 2 quarter, 3 programmable, 4 external, 5-7 off |
| div_i | input | 8 | Reload value N for the programmable rate |
| ext_clk_i | input | 1 | External sample clock, asynchronous |
| rate_o | output | 1 | Gated sample-rate pulse |
| conv_a_o | output | 1 | Conversion enable for converter A |
| conv_b_o | output | 1 | Conversion enable for converter B |

## Verification
The emission of a pulse and the take-up of a new rate setting fall in the same cycle, because the configuration register loads exactly where the old period ends. The bench provokes this by changing the code or the reload value partway through a long programmable period. It judges the result by measuring that the interval already running keeps its old length. It then checks that the next interval, or the very next cycle in the case of code 0, follows the new setting.

// File: rtl/sr_pkg.sv
package sr_pkg;
  localparam int SEL_W = 3;
  typedef logic [SEL_W-1:0] rate_sel_t;

  localparam rate_sel_t SEL_FULL    = 3'd0;
  localparam rate_sel_t SEL_HALF    = 3'd1;
  localparam rate_sel_t SEL_QUARTER = 3'd2;
  localparam rate_sel_t SEL_PROG    = 3'd3;
  localparam rate_sel_t SEL_EXT     = 3'd4;
endpackage

// File: rtl/sr_cfg_hold.sv
module sr_cfg_hold
  import sr_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_n,
  input  logic             load_i,
  input  rate_sel_t        sel_i,
  input  logic [DIV_W-1:0] div_i,
  output rate_sel_t        sel_q,
  output logic [DIV_W-1:0] div_q
);
  rate_sel_t        sel_d;
  logic [DIV_W-1:0] div_d;

  always_comb begin
    sel_d = sel_q;
    div_d = div_q;
    if (load_i) begin
      sel_d = sel_i;
      div_d = div_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= SEL_FULL;
      div_q <= '0;
    end else begin
      sel_q <= sel_d;
      div_q <= div_d;
    end
  end
endmodule

// File: rtl/sr_period.sv
module sr_period
  import sr_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int PRE_LOG2 = 4
) (
  input  logic             clk_i,
  input  logic             rst_n,
  input  logic             restart_i,
  input  rate_sel_t        sel_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             is_int_o,
  output logic             wrap_o
);
  localparam int CNT_W = DIV_W + PRE_LOG2;

  logic [CNT_W-1:0] cnt_q, cnt_d, last;

  always_comb begin
    is_int_o = 1'b1;
    unique case (sel_i)
      SEL_FULL:    last = '0;
      SEL_HALF:    last = CNT_W'(1);
      SEL_QUARTER: last = CNT_W'(3);
      SEL_PROG:    last = {div_i, {PRE_LOG2{1'b1}}};
      default: begin
        last     = '0;
        is_int_o = 1'b0;
      end
    endcase
    wrap_o = is_int_o && (cnt_q == last);
    cnt_d  = restart_i ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sr_ext_edge.sv
module sr_ext_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n,
  input  logic ext_i,
  output logic rise_o
);
  logic [SYNC_STAGES:0] sh_q, sh_d;

  always_comb begin
    sh_d   = {sh_q[SYNC_STAGES-1:0], ext_i};
    rise_o = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end
endmodule

// File: rtl/sr_phase_split.sv
module sr_phase_split (
  input  logic clk_i,
  input  logic rst_n,
  input  logic en_i,
  input  logic tick_i,
  output logic rate_o,
  output logic conv_a_o,
  output logic conv_b_o
);
  logic ph_q, ph_d;

  always_comb begin
    if (!en_i)       ph_d = 1'b0;
    else if (tick_i) ph_d = ~ph_q;
    else             ph_d = ph_q;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= 1'b0;
      rate_o   <= 1'b0;
      conv_a_o <= 1'b0;
      conv_b_o <= 1'b0;
    end else begin
      ph_q     <= ph_d;
      rate_o   <= tick_i;
      conv_a_o <= tick_i & ~ph_q;
      conv_b_o <= tick_i &  ph_q;
    end
  end
endmodule

// File: rtl/sample_rate_gen.sv
module sample_rate_gen
  import sr_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int PRE_LOG2    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [2:0]       sel_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             ext_clk_i,
  output logic             rate_o,
  output logic             conv_a_o,
  output logic             conv_b_o
);
  logic [1:0]       rst_pipe;
  logic             rst_s_n;
  rate_sel_t        act_sel;
  logic [DIV_W-1:0] act_div;
  logic             is_int, wrap, ext_rise, tick, load;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  always_comb begin
    tick = en_i & (wrap | ((act_sel == SEL_EXT) & ext_rise));
    load = ~en_i | tick | ~is_int;
  end

  sr_cfg_hold #(.DIV_W(DIV_W)) u_cfg (
    .clk_i(clk_i), .rst_n(rst_s_n), .load_i(load),
    .sel_i(sel_i), .div_i(div_i), .sel_q(act_sel), .div_q(act_div)
  );

  sr_period #(.DIV_W(DIV_W), .PRE_LOG2(PRE_LOG2)) u_period (
    .clk_i(clk_i), .rst_n(rst_s_n), .restart_i(load),
    .sel_i(act_sel), .div_i(act_div), .is_int_o(is_int), .wrap_o(wrap)
  );

  sr_ext_edge #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
    .clk_i(clk_i), .rst_n(rst_s_n), .ext_i(ext_clk_i), .rise_o(ext_rise)
  );

  sr_phase_split u_split (
    .clk_i(clk_i), .rst_n(rst_s_n), .en_i(en_i), .tick_i(tick),
    .rate_o(rate_o), .conv_a_o(conv_a_o), .conv_b_o(conv_b_o)
  );
endmodule

// File: rtl/sr_chk.sv
module sr_chk (
  input logic       clk_i,
  input logic       rst_n,
  input logic       en_i,
  input logic [2:0] sel_i,
  input logic       rate_o,
  input logic       conv_a_o,
  input logic       conv_b_o
);
  logic last_a;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      last_a <= 1'b0;
    end else begin
      if (rate_o) last_a <= conv_a_o;
      if (!en_i)  last_a <= 1'b0;
    end
  end

  // R8
  conv_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $countones({conv_a_o, conv_b_o}) == (rate_o ? 1 : 0));

  // R8
  conv_alternate_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    rate_o |-> (conv_a_o == !last_a));

  // R7
  enable_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !en_i |=> (!rate_o && !conv_a_o && !conv_b_o));

  // R9
  full_rate_take_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rate_o && en_i && $past(sel_i) == 3'd0) |=> rate_o);
endmodule

bind sample_rate_gen sr_chk u_chk (
  .clk_i(clk_i), .rst_n(rst_n), .en_i(en_i), .sel_i(sel_i),
  .rate_o(rate_o), .conv_a_o(conv_a_o), .conv_b_o(conv_b_o)
);

// File: tb/sample_rate_gen_bench.sv
module sample_rate_gen_bench;
  localparam int CLK_NS = 10;

  logic       clk_i = 1'b0;
  logic       rst_n;
  logic       en_i;
  logic [2:0] sel_i;
  logic [7:0] div_i;
  logic       ext_clk_i;
  logic       rate_o, conv_a_o, conv_b_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #(CLK_NS/2) clk_i = ~clk_i;

  sample_rate_gen u_sample_rate_gen (
    .clk_i(clk_i), .rst_n(rst_n), .en_i(en_i), .sel_i(sel_i),
    .div_i(div_i), .ext_clk_i(ext_clk_i),
    .rate_o(rate_o), .conv_a_o(conv_a_o), .conv_b_o(conv_b_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_pulse(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk_i);
      cyc++;
    end while (!rate_o && cyc < 10000);
  endtask

  task automatic count_pulses(input int cycles, output int cnt);
    cnt = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk_i);
      if (rate_o || conv_a_o || conv_b_o) cnt++;
    end
  endtask

  task automatic arm(input logic [2:0] code, input logic [7:0] n);
    @(negedge clk_i);
    en_i = 1'b0; sel_i = code; div_i = n;
    repeat (2) @(negedge clk_i);
    en_i = 1'b1;
  endtask

  task automatic run_rate(input string tag, input logic [2:0] code,
                          input logic [7:0] n, input int len);
    int cyc;
    arm(code, n);
    wait_pulse(cyc);
    check({tag, " first latency (R7)"}, cyc, len);
    check({tag, " first to conv_a (R8)"}, {conv_a_o, conv_b_o}, 2);
    wait_pulse(cyc);
    check({tag, " period"}, cyc, len);
    check({tag, " second to conv_b (R8)"}, {conv_a_o, conv_b_o}, 1);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int cyc, cnt;
    rst_n = 1'b0; en_i = 1'b1; sel_i = 3'd0; div_i = 8'd0; ext_clk_i = 1'b0;
    repeat (3) @(negedge clk_i);
    // R1: enable high and full rate selected, still silent in reset
    check("R1 outputs in reset", {rate_o, conv_a_o, conv_b_o}, 0);
    rst_n = 1'b1;
    @(negedge clk_i);
    check("R1 outputs during release", {rate_o, conv_a_o, conv_b_o}, 0);
    en_i = 1'b0;
    repeat (4) @(negedge clk_i);

    // R2, R3
    run_rate("R2 code0", 3'd0, 8'd0, 1);
    count_pulses(40, cnt);
    check("R2 continuous pulses", cnt, 40);
    run_rate("R3 code1", 3'd1, 8'd0, 2);
    run_rate("R3 code2", 3'd2, 8'd0, 4);

    // R4 sweep of reload values
    for (int n = 0; n < 8; n++)
      run_rate($sformatf("R4 code3 N=%0d", n), 3'd3, 8'(n), 16 * (n + 1));
    run_rate("R4 code3 N=15", 3'd3, 8'd15, 256);
    run_rate("R4 code3 N=127", 3'd3, 8'd127, 2048);
    run_rate("R4 code3 N=255", 3'd3, 8'd255, 4096);

    // R6
    for (int c = 5; c < 8; c++) begin
      arm(3'(c), 8'd0);
      count_pulses(100, cnt);
      check($sformatf("R6 code%0d silent", c), cnt, 0);
    end

    // R7: enable low gates full rate
    @(negedge clk_i);
    en_i = 1'b0; sel_i = 3'd0;
    count_pulses(50, cnt);
    check("R7 disabled silent", cnt, 0);

    // R5 external clock
    arm(3'd4, 8'd0);
    repeat (5) @(negedge clk_i);
    ext_clk_i = 1'b1;
    wait_pulse(cyc);
    check("R5 ext latency", cyc, 3);
    check("R5 ext first conv_a (R8)", {conv_a_o, conv_b_o}, 2);
    count_pulses(20, cnt);
    check("R5 held level single pulse", cnt, 0);
    ext_clk_i = 1'b0;
    repeat (6) @(negedge clk_i);
    ext_clk_i = 1'b1;
    wait_pulse(cyc);
    check("R5 second edge latency", cyc, 3);
    check("R5 second edge conv_b (R8)", {conv_a_o, conv_b_o}, 1);
    ext_clk_i = 1'b0;

    // R9: code change mid-period takes effect at boundary
    arm(3'd3, 8'd3);
    wait_pulse(cyc);
    check("R9 setup period", cyc, 64);
    cyc = 0;
    do begin
      @(negedge clk_i);
      cyc++;
      if (cyc == 10) sel_i = 3'd0;
    end while (!rate_o && cyc < 10000);
    check("R9 old period kept", cyc, 64);
    count_pulses(5, cnt);
    check("R9 new full rate follows", cnt, 5);

    // R9: reload change mid-period
    arm(3'd3, 8'd3);
    wait_pulse(cyc);
    cyc = 0;
    do begin
      @(negedge clk_i);
      cyc++;
      if (cyc == 5) div_i = 8'd1;
    end while (!rate_o && cyc < 10000);
    check("R9 reload old period kept", cyc, 64);
    wait_pulse(cyc);
    check("R9 reload new period", cyc, 32);

    // R9: switch to off code waits for boundary, then silent
    arm(3'd2, 8'd0);
    wait_pulse(cyc);
    @(negedge clk_i);
    sel_i = 3'd6;
    wait_pulse(cyc);
    check("R9 off code after boundary", cyc, 3);
    count_pulses(30, cnt);
    check("R9 off code silent (R6)", cnt, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule